// File: doc/BRIEF.md
# Polled Internet Checksum Engine

This block is a bus peripheral. It computes the 16-bit ones'-complement Internet checksum of a buffer that sits in system memory. Software programs a byte address and a byte count through a small 32-bit register port. The write of the count is the start command. The engine then fetches the buffer by itself through a read-master port, one aligned 32-bit word at a time. Each request is held until memory accepts it, and the data comes back later with a valid strobe.

Software learns that the run is over by polling a status word, then reads the result word. Bytes are paired into big-endian 16-bit words, counted from the first byte of the buffer and not from the word boundary. Bytes of a fetched word that fall outside the buffer are dropped. A buffer with an odd length is padded with a zero low byte.

Top module: `csum_engine`

## Requirements
- R1: Register decode on `s_addr`: 0 is the start byte address, 1 is the byte count, 2 is the completion flag and 3 is the checksum. Reading 0 or 1 returns the last accepted value. A read presents its data on `s_rdata` at the clock edge that samples `s_rd`.
- R2: Writing register 0 alone starts no fetch and leaves the completion flag unchanged.
- R3: Writing register 1 while idle starts a run. From the next edge the completion flag reads 0. Once the run ends it reads 1, and it stays 1 until the next start.
- R4: Register 3 reads the bitwise inverse of the end-around-carry ones'-complement sum of the buffer taken as big-endian 16-bit words: buffer byte 0 is a high byte, buffer byte 1 a low byte, and so on. The value is zero-extended to 32 bits.
- R5: A run of length N at address A requests every word address from (A/4)*4 to ((A+N-1)/4)*4, each exactly once, in ascending order. `m_addr` bits 1:0 are always 0. A request stays asserted with a stable address until `m_ack`.
- R6: Memory data is little-endian by lane: the byte at address a is `m_rdata[8*(a%4) +: 8]`. Bytes of a fetched word below A, or at or above A+N, do not affect the result.
- R7: With an odd count, the last byte is the high byte of a final word whose low byte is zero.
- R8: A count of zero issues no request, sets the completion flag, and gives a result of 0x0000FFFF.
- R9: A write to register 1 during a run is ignored. The run, its fetches, its result and the count readback are unchanged.
- R10: Register 3 keeps the previous result until the current run completes.
- R11: A synchronous active-high reset clears every register to 0, drops `m_req` and idles the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_wr | input | 1 | Register write strobe |
| s_rd | input | 1 | Register read strobe |
| s_addr | input | 2 | Register word offset |
| s_wdata | input | 32 | Register write data |
| s_rdata | output | 32 | Registered read data |
| m_req | output | 1 | Memory read request, held until accepted |
| m_addr | output | AW | Word-aligned byte address of the request |
| m_ack | input | 1 | Memory accepts the request this cycle |
| m_rvalid | input | 1 | Read data valid |
| m_rdata | input | DW | Read data, little-endian byte lanes |

## Verification
A corrupt word pointer or lane mask shows up within one fetch. It appears either as a request address that differs from the next expected word, or as a checksum mismatch once the run ends. A wrong sequencer state shows up at the ports in one of three ways: a request that should not exist, a completion flag that rises too early or never rises, or a request whose address moves before acceptance. Runs with unaligned starts, odd counts, an all-0xFF buffer and a zero count exercise parity tracking and carry folding. Any error there surfaces as a wrong result word on the first poll after completion.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_REQ,
    FS_WAIT,
    FS_FIN
  } fetch_state_t;

  localparam logic [1:0] OFS_START = 2'd0;
  localparam logic [1:0] OFS_LEN   = 2'd1;
  localparam logic [1:0] OFS_DONE  = 2'd2;
  localparam logic [1:0] OFS_SUM   = 2'd3;
endpackage

// File: rtl/csum_fetch.sv
module csum_fetch
  import csum_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] byte_len,
  output logic          m_req,
  output logic [AW-1:0] m_addr,
  input  logic          m_ack,
  input  logic          m_rvalid,
  output logic          beat_valid,
  output logic [DW/8-1:0] beat_mask,
  output logic          start_odd,
  output logic          busy,
  output logic          fin
);
  localparam int NB = DW / 8;
  localparam int LB = $clog2(NB);
  localparam int EW = AW + 1;
  localparam int WW = AW - LB;

  fetch_state_t state;
  logic [WW-1:0] cur_w, last_w;
  logic [EW-1:0] lo_b, hi_b;
  logic [EW-1:0] end_b, end_m1;

  assign end_b  = {1'b0, start_addr} + {{(EW-LW){1'b0}}, byte_len};
  assign end_m1 = end_b - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FS_IDLE;
      cur_w  <= '0;
      last_w <= '0;
      lo_b   <= '0;
      hi_b   <= '0;
    end else begin
      case (state)
        FS_IDLE: if (go) begin
          lo_b   <= {1'b0, start_addr};
          hi_b   <= end_b;
          cur_w  <= start_addr[AW-1:LB];
          last_w <= end_m1[AW-1:LB];
          state  <= (byte_len == '0) ? FS_FIN : FS_REQ;
        end
        FS_REQ:  if (m_ack) state <= FS_WAIT;
        FS_WAIT: if (m_rvalid) begin
          if (cur_w == last_w) state <= FS_FIN;
          else begin
            cur_w <= cur_w + 1'b1;
            state <= FS_REQ;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign m_req      = (state == FS_REQ);
  assign m_addr     = {cur_w, {LB{1'b0}}};
  assign beat_valid = (state == FS_WAIT) && m_rvalid;
  assign busy       = (state != FS_IDLE);
  assign fin        = (state == FS_FIN);
  assign start_odd  = lo_b[0];

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [EW-1:0] lane_b;
    assign lane_b       = {1'b0, cur_w, LB'(k)};
    assign beat_mask[k] = (lane_b >= lo_b) && (lane_b < hi_b);
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr)));

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (go && state == FS_IDLE && byte_len == '0) |=> (!m_req && fin));
endmodule

// File: rtl/csum_accum.sv
module csum_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          beat_valid,
  input  logic [DW-1:0] beat_data,
  input  logic [DW/8-1:0] beat_mask,
  input  logic          start_odd,
  output logic [15:0]   sum_q
);
  localparam int NB = DW / 8;
  localparam int LB = $clog2(NB);
  localparam int CW = 16 + LB + 1;
  localparam int TW = CW + 1;

  logic [CW-1:0] contrib;
  logic [7:0]    lane_v;
  logic [TW-1:0] total;
  logic [16:0]   fold1;
  logic [15:0]   fold2;

  // a lane holds a high byte when its parity matches the start address parity
  always_comb begin
    contrib = '0;
    lane_v  = '0;
    for (int k = 0; k < NB; k++) begin
      lane_v = beat_data[8*k +: 8];
      if (beat_mask[k]) begin
        if ((k % 2 == 1) == start_odd) contrib = contrib + CW'({lane_v, 8'h00});
        else                           contrib = contrib + CW'(lane_v);
      end
    end
  end

  assign total = TW'(sum_q) + TW'(contrib);
  assign fold1 = {1'b0, total[15:0]} + 17'(total[TW-1:16]);
  assign fold2 = fold1[15:0] + 16'(fold1[16]);

  always_ff @(posedge clk) begin
    if (rst || clr)      sum_q <= '0;
    else if (beat_valid) sum_q <= fold2;
  end
endmodule

// File: rtl/csum_engine.sv
module csum_engine
  import csum_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_wr,
  input  logic          s_rd,
  input  logic [1:0]    s_addr,
  input  logic [31:0]   s_wdata,
  output logic [31:0]   s_rdata,
  output logic          m_req,
  output logic [AW-1:0] m_addr,
  input  logic          m_ack,
  input  logic          m_rvalid,
  input  logic [DW-1:0] m_rdata
);
  localparam int NB = DW / 8;

  logic [AW-1:0] start_q;
  logic [LW-1:0] len_q;
  logic          done_q;
  logic [15:0]   result_q;
  logic          go, busy, fin, beat_valid, start_odd;
  logic [NB-1:0] beat_mask;
  logic [15:0]   sum_q;

  assign go = s_wr && (s_addr == OFS_LEN) && !busy;

  csum_fetch #(.AW(AW), .LW(LW), .DW(DW)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .start_addr (start_q),
    .byte_len   (s_wdata[LW-1:0]),
    .m_req      (m_req),
    .m_addr     (m_addr),
    .m_ack      (m_ack),
    .m_rvalid   (m_rvalid),
    .beat_valid (beat_valid),
    .beat_mask  (beat_mask),
    .start_odd  (start_odd),
    .busy       (busy),
    .fin        (fin)
  );

  csum_accum #(.DW(DW)) u_accum (
    .clk        (clk),
    .rst        (rst),
    .clr        (go),
    .beat_valid (beat_valid),
    .beat_data  (m_rdata),
    .beat_mask  (beat_mask),
    .start_odd  (start_odd),
    .sum_q      (sum_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      len_q    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
      s_rdata  <= '0;
    end else begin
      if (s_wr && s_addr == OFS_START) start_q <= s_wdata[AW-1:0];
      if (go) begin
        len_q  <= s_wdata[LW-1:0];
        done_q <= 1'b0;
      end
      if (fin) begin
        result_q <= ~sum_q;
        done_q   <= 1'b1;
      end
      if (s_rd) begin
        case (s_addr)
          OFS_START: s_rdata <= 32'(start_q);
          OFS_LEN:   s_rdata <= 32'(len_q);
          OFS_DONE:  s_rdata <= 32'(done_q);
          default:   s_rdata <= 32'(result_q);
        endcase
      end
    end
  end

  // R3
  busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done_q);

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    (s_wr && s_addr == OFS_LEN && busy) |=> $stable(len_q));

  // R10
  sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> $stable(result_q));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done_q && result_q == '0 && !m_req));
endmodule

// File: tb/csum_engine_tb.sv
module csum_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_wr = 1'b0, s_rd = 1'b0;
  logic [1:0]  s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic        m_req;
  logic [31:0] m_addr;
  logic        m_ack, m_rvalid;
  logic [31:0] m_rdata;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0]  mem [256];
  logic [31:0] exp_q [$];
  logic [15:0] lfsr;
  logic        rsp_busy;
  logic [1:0]  rsp_wait;
  logic [31:0] rsp_addr;
  logic [31:0] prev_result = 32'h0;

  always #10 clk = ~clk;

  csum_engine u_dut (
    .clk(clk), .rst(rst), .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .m_req(m_req), .m_addr(m_addr),
    .m_ack(m_ack), .m_rvalid(m_rvalid), .m_rdata(m_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[8'(a)]};
  endfunction

  // memory responder with pseudo-random accept and data latency
  always @(posedge clk) begin
    if (rst) begin
      m_ack <= 1'b0; m_rvalid <= 1'b0; m_rdata <= '0;
      rsp_busy <= 1'b0; rsp_wait <= '0; rsp_addr <= '0; lfsr <= 16'hACE1;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_rvalid <= 1'b0;
      if (m_req && m_ack) begin
        m_ack <= 1'b0; rsp_busy <= 1'b1; rsp_wait <= {1'b0, lfsr[0]}; rsp_addr <= m_addr;
      end else if (rsp_busy) begin
        if (rsp_wait == 0) begin
          m_rvalid <= 1'b1; m_rdata <= mem_word(rsp_addr); rsp_busy <= 1'b0;
        end else rsp_wait <= rsp_wait - 1'b1;
      end else m_ack <= m_req && lfsr[1];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model of the fetch order, compared on every clock
  always @(negedge clk) begin
    if (!rst && m_req && m_ack) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected fetch", m_addr, 32'hFFFF_FFFF);
      else begin
        chk(m_addr == exp_q[0], "R5 fetch address", m_addr, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    s_wr = 1'b1; s_addr = a; s_wdata = d;
    @(negedge clk);
    s_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    s_rd = 1'b1; s_addr = a;
    @(negedge clk);
    s_rd = 1'b0;
    d = s_rdata;
  endtask

  function automatic logic [31:0] ref_sum(input int s, input int n);
    int acc = 0;
    for (int i = 0; i < n; i += 2) begin
      int hi = int'(mem[8'(s+i)]);
      int lo = (i + 1 < n) ? int'(mem[8'(s+i+1)]) : 0;
      acc = acc + (hi * 256 + lo);
      acc = (acc & 32'hFFFF) + (acc >>> 16);
    end
    return 32'(~acc & 32'hFFFF);
  endfunction

  task automatic run(input int s, input int n, input int late_len, input string req);
    logic [31:0] v, e;
    int polls = 0;
    if (n > 0) for (int w = s / 4; w <= (s + n - 1) / 4; w++) exp_q.push_back(32'(w * 4));
    e = ref_sum(s, n);
    wr(2'd0, 32'(s));
    wr(2'd1, 32'(n));
    if (late_len >= 0) wr(2'd1, 32'(late_len));
    if (n > 0) begin
      rd(2'd3, v); chk(v == prev_result, "R10 result held during run", v, prev_result);
      rd(2'd2, v); chk(v == 0, "R3 done low while running", v, 32'h0);
    end
    v = 0;
    while (v == 0 && polls < 300) begin rd(2'd2, v); polls++; end
    chk(v != 0, "R3 done set at end", v, 32'h1);
    rd(2'd3, v); chk(v == e, req, v, e);
    rd(2'd1, v); chk(v == 32'(n), "R1 R9 length readback", v, 32'(n));
    chk(exp_q.size() == 0, "R5 all words fetched", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
    prev_result = e;
  endtask

  initial begin
    logic [31:0] v;
    bit quiet;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 128; i < 160; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk(v == 0, "R11 register after reset", v, 32'h0);
    end
    chk(m_req == 0, "R11 no request after reset", 32'(m_req), 32'h0);
    // R2 address write alone
    wr(2'd0, 32'h10);
    quiet = 1'b1;
    repeat (8) begin @(negedge clk); if (m_req) quiet = 1'b0; end
    chk(quiet, "R2 no fetch from address write", 32'(!quiet), 32'h0);
    rd(2'd2, v); chk(v == 0, "R2 done unchanged", v, 32'h0);
    rd(2'd0, v); chk(v == 32'h10, "R1 start readback", v, 32'h10);
    // R4 aligned, R6 R7 unaligned and odd
    run(16, 16, -1, "R4 aligned checksum");
    run(33, 11, -1, "R6 R7 odd start odd length");
    run(66, 7, -1, "R6 R7 misaligned odd length");
    run(19, 1, -1, "R7 single byte");
    run(128, 32, -1, "R4 all ones fold");
    run(1, 200, -1, "R4 long buffer");
    // R8 zero length
    run(48, 0, -1, "R8 zero length result");
    // R9 late length write ignored
    run(80, 24, 5, "R9 busy write ignored");
    run(2, 6, -1, "R4 R6 after ignored write");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule